// File: doc/BRIEF.md
# Binary-Tree Piecewise-Affine Evaluator

This block evaluates a piecewise-affine function of up to four signed fixed-point inputs. It walks a binary search tree that is held in a programmable node memory. Each node entry holds an address into a coefficient memory. Each coefficient word holds one affine form: four input weights and one offset. At every node the block computes the weighted sum of the inputs plus the offset. At an internal node the sign of that sum chooses which child to visit next. At the last level the same sum is the function value, and it is registered and driven out.

The caller fills both memories through their write ports and presents the inputs and the configuration. It then pulses `start`. The block captures the inputs, the active input count and the tree depth, and `busy` rises. A single multiply-accumulate datapath, made of four parallel multipliers and an adder, serves both the branch decisions and the leaf value. Each level costs one node-memory read and one coefficient-memory read. A one-cycle `valid_out` pulse marks the new result.

Top module: `pwa_tree_eval`

## Requirements
- R1: While reset is active and directly after it, `busy`, `valid_out` and `result` are all zero.
- R2: A coefficient word packs five signed 12-bit fields. The offset sits in bits [11:0] and the weight for input j (j = 0..3) sits in bits [12(j+1)+11 : 12(j+1)]. The value of a node is the offset plus the sum of weight·input over the active inputs. It is computed in two's complement and sign-extended to 26 bits, and at the leaf it is driven on `result`.
- R3: Nodes are stored breadth-first from index 0. Each node-memory entry is a coefficient-memory address. From node i the walk moves to node 2i+1 when the node value is at most zero and to node 2i+2 when it is positive.
- R4: A node value of exactly zero selects child 2i+1.
- R5: With a configured depth of d, `valid_out` pulses high for exactly one cycle, 2d+2 clock edges after the edge that accepts `start`. `busy` is high from the edge after acceptance until the pulse, and low during the pulse.
- R6: A depth value of 0 is treated as 1. A depth above the maximum (9 with the default node-memory size) is treated as the maximum.
- R7: Only inputs 0..n−1 take part in the sum, and the other lanes count as zero. A count of 0 is treated as 1, and a count above 4 is treated as 4.
- R8: A `start` pulse while `busy` is high is ignored. It produces no extra result and no extra busy period.
- R9: `result` holds its value between `valid_out` pulses.
- R10: The inputs, the input count and the depth are captured when `start` is accepted. Changing them during an evaluation does not change its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an evaluation (taken only while idle) |
| n_inputs | input | 3 | Number of active inputs, 1..4 |
| depth | input | 4 | Number of decision levels, 1..9 |
| x_in | input | 48 | Four signed 12-bit inputs, input j at bits [12j+11:12j] |
| tree_we | input | 1 | Node-memory write enable |
| tree_waddr | input | 10 | Node-memory write address |
| tree_wdata | input | 10 | Node entry: coefficient-memory address |
| par_we | input | 1 | Coefficient-memory write enable |
| par_waddr | input | 10 | Coefficient-memory write address |
| par_wdata | input | 60 | Coefficient word (layout in R2) |
| busy | output | 1 | Evaluation in progress |
| valid_out | output | 1 | One-cycle pulse: `result` is new |
| result | output | 26 | Signed leaf value |

## Verification
The bound checker watches the handshake on every cycle. It checks that an accepted start raises `busy`, that `busy` ends only with a done pulse, that the pulse lasts one cycle and arrives with `busy` low, and that `result` moves only with the pulse. The arithmetic and the tree walk can only be shown by the bench's scenarios. These cover the path taken, the zero-sum branch, lane masking, the clamping of the depth and the input count, the exact latency per depth, and the capture of the inputs against later changes. The bench compares each result against a model that walks its own copy of both memories.

// File: rtl/pwa_pkg.sv
package pwa_pkg;

    // Evaluator sequencing states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TREE  = 2'd1,
        ST_PARAM = 2'd2
    } eval_state_e;

endpackage

// File: rtl/pwa_mem.sv
// Behavioural single-write, asynchronous-read memory array.
module pwa_mem #(
    parameter int W  = 12,
    parameter int AW = 10,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/pwa_affine_unit.sv
// Parallel multiply-accumulate: offset + sum of weight*input over active lanes.
module pwa_affine_unit #(
    parameter int IN_W   = 12,
    parameter int COEF_W = 12,
    parameter int OUT_W  = 26,
    parameter int MAX_IN = 4,
    parameter int NIN_W  = 3,
    localparam int PROD_W  = IN_W + COEF_W,
    localparam int PWORD_W = (MAX_IN + 1) * COEF_W
) (
    input  logic [MAX_IN*IN_W-1:0] x_i,
    input  logic [PWORD_W-1:0]     coef_i,
    input  logic [NIN_W-1:0]       n_act_i,
    output logic [OUT_W-1:0]       sum_o
);

    logic signed [PROD_W-1:0] prod [MAX_IN];

    for (genvar j = 0; j < MAX_IN; j++) begin : g_lane
        logic               lane_on;
        logic signed [IN_W-1:0]   xv;
        logic signed [COEF_W-1:0] hv;
        assign lane_on = (NIN_W'(j) < n_act_i);
        assign xv      = lane_on ? x_i[j*IN_W +: IN_W] : '0;
        assign hv      = coef_i[(j+1)*COEF_W +: COEF_W];
        assign prod[j] = hv * xv;
    end

    logic [COEF_W-1:0] k_raw;
    logic [OUT_W-1:0]  acc;

    assign k_raw = coef_i[COEF_W-1:0];

    always_comb begin
        acc = {{(OUT_W-COEF_W){k_raw[COEF_W-1]}}, k_raw};
        for (int j = 0; j < MAX_IN; j++) begin
            acc = acc + {{(OUT_W-PROD_W){prod[j][PROD_W-1]}}, prod[j]};
        end
    end

    assign sum_o = acc;

endmodule

// File: rtl/pwa_tree_eval.sv
// Tree-walking piecewise-affine evaluator: sequencer plus memories and datapath.
module pwa_tree_eval
    import pwa_pkg::*;
#(
    parameter int IN_W    = 12,
    parameter int COEF_W  = 12,
    parameter int OUT_W   = 26,
    parameter int MAX_IN  = 4,
    parameter int TREE_AW = 10,
    parameter int PAR_AW  = 10,
    localparam int MAX_DEPTH = TREE_AW - 1,
    localparam int LVL_W     = $clog2(MAX_DEPTH + 1),
    localparam int NIN_W     = $clog2(MAX_IN + 1),
    localparam int PWORD_W   = (MAX_IN + 1) * COEF_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [NIN_W-1:0]       n_inputs,
    input  logic [LVL_W-1:0]       depth,
    input  logic [MAX_IN*IN_W-1:0] x_in,
    input  logic                   tree_we,
    input  logic [TREE_AW-1:0]     tree_waddr,
    input  logic [PAR_AW-1:0]      tree_wdata,
    input  logic                   par_we,
    input  logic [PAR_AW-1:0]      par_waddr,
    input  logic [PWORD_W-1:0]     par_wdata,
    output logic                   busy,
    output logic                   valid_out,
    output logic [OUT_W-1:0]       result
);

    typedef struct packed {
        eval_state_e             st;
        logic [TREE_AW-1:0]      node;
        logic [LVL_W-1:0]        level;
        logic [LVL_W-1:0]        lim;
        logic [NIN_W-1:0]        nin;
        logic [MAX_IN*IN_W-1:0]  x;
        logic [PAR_AW-1:0]       paddr;
        logic                    valid;
        logic [OUT_W-1:0]        res;
    } eval_regs_t;

    eval_regs_t r_d, r_q;

    logic [PAR_AW-1:0]  tree_rdata;
    logic [PWORD_W-1:0] par_rdata;
    logic [OUT_W-1:0]   node_sum;

    pwa_mem #(.W(PAR_AW), .AW(TREE_AW)) tree_mem_i (
        .clk   (clk),
        .we    (tree_we),
        .waddr (tree_waddr),
        .wdata (tree_wdata),
        .raddr (r_q.node),
        .rdata (tree_rdata)
    );

    pwa_mem #(.W(PWORD_W), .AW(PAR_AW)) par_mem_i (
        .clk   (clk),
        .we    (par_we),
        .waddr (par_waddr),
        .wdata (par_wdata),
        .raddr (r_q.paddr),
        .rdata (par_rdata)
    );

    pwa_affine_unit #(
        .IN_W   (IN_W),
        .COEF_W (COEF_W),
        .OUT_W  (OUT_W),
        .MAX_IN (MAX_IN),
        .NIN_W  (NIN_W)
    ) affine_i (
        .x_i     (r_q.x),
        .coef_i  (par_rdata),
        .n_act_i (r_q.nin),
        .sum_o   (node_sum)
    );

    logic               sum_pos;
    logic [TREE_AW-1:0] child;
    logic [LVL_W-1:0]   lim_clamped;
    logic [NIN_W-1:0]   nin_clamped;

    assign sum_pos = $signed(node_sum) > 0;
    assign child   = {r_q.node[TREE_AW-2:0], 1'b0} + (sum_pos ? TREE_AW'(2) : TREE_AW'(1));

    always_comb begin
        if (depth == '0) begin
            lim_clamped = LVL_W'(1);
        end else if (depth > LVL_W'(MAX_DEPTH)) begin
            lim_clamped = LVL_W'(MAX_DEPTH);
        end else begin
            lim_clamped = depth;
        end
        if (n_inputs == '0) begin
            nin_clamped = NIN_W'(1);
        end else if (n_inputs > NIN_W'(MAX_IN)) begin
            nin_clamped = NIN_W'(MAX_IN);
        end else begin
            nin_clamped = n_inputs;
        end
    end

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_TREE;
                    r_d.node  = '0;
                    r_d.level = '0;
                    r_d.lim   = lim_clamped;
                    r_d.nin   = nin_clamped;
                    r_d.x     = x_in;
                end
            end
            ST_TREE: begin
                r_d.paddr = tree_rdata;
                r_d.st    = ST_PARAM;
            end
            ST_PARAM: begin
                if (r_q.level == r_q.lim) begin
                    r_d.res   = node_sum;
                    r_d.valid = 1'b1;
                    r_d.st    = ST_IDLE;
                end else begin
                    r_d.node  = child;
                    r_d.level = r_q.level + LVL_W'(1);
                    r_d.st    = ST_TREE;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign valid_out = r_q.valid;
    assign result    = r_q.res;

endmodule

// File: rtl/pwa_tree_eval_chk.sv
// Handshake checker bound to the evaluator.
module pwa_tree_eval_chk #(
    parameter int OUT_W = 26
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             valid_out,
    input logic [OUT_W-1:0] result
);

    // R5: an accepted start makes the block busy on the next cycle
    assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R5: the done pulse lasts a single cycle
    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |=> !valid_out);

    // R5: a done pulse only follows a busy cycle
    assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> $past(busy));

    // R5: busy ends only together with a done pulse
    assert_busy_until_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || valid_out));

    // R8: the block is idle during the pulse, so no restart overlaps a run
    assert_idle_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> !busy);

    // R9: the result moves only with a done pulse
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_out |-> $stable(result));

endmodule

bind pwa_tree_eval pwa_tree_eval_chk #(.OUT_W(OUT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .valid_out (valid_out),
    .result    (result)
);

// File: tb/pwa_tree_eval_tb_top.sv
module pwa_tree_eval_tb_top;

    localparam int IN_W    = 12;
    localparam int COEF_W  = 12;
    localparam int OUT_W   = 26;
    localparam int MAX_IN  = 4;
    localparam int TREE_AW = 10;
    localparam int PAR_AW  = 10;
    localparam int MAXD    = TREE_AW - 1;
    localparam int PWORD_W = (MAX_IN + 1) * COEF_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] n_inputs = '0;
    logic [3:0] depth = '0;
    logic [MAX_IN*IN_W-1:0] x_in = '0;
    logic tree_we = 1'b0;
    logic [TREE_AW-1:0] tree_waddr = '0;
    logic [PAR_AW-1:0] tree_wdata = '0;
    logic par_we = 1'b0;
    logic [PAR_AW-1:0] par_waddr = '0;
    logic [PWORD_W-1:0] par_wdata = '0;
    logic busy, valid_out;
    logic [OUT_W-1:0] result;

    always #2 clk = ~clk;

    pwa_tree_eval dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .n_inputs(n_inputs), .depth(depth),
        .x_in(x_in), .tree_we(tree_we), .tree_waddr(tree_waddr), .tree_wdata(tree_wdata),
        .par_we(par_we), .par_waddr(par_waddr), .par_wdata(par_wdata),
        .busy(busy), .valid_out(valid_out), .result(result)
    );

    logic [PAR_AW-1:0]  tree_m [1<<TREE_AW];
    logic [PWORD_W-1:0] par_m  [1<<PAR_AW];

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;
    logic [OUT_W-1:0] last_exp = '0;

    logic [OUT_W-1:0] q_res[$];
    int               q_cyc[$];
    string            q_tag[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int clamp_d(input int d);
        if (d == 0) return 1;
        if (d > MAXD) return MAXD;
        return d;
    endfunction

    function automatic int clamp_n(input int n);
        if (n == 0) return 1;
        if (n > MAX_IN) return MAX_IN;
        return n;
    endfunction

    function automatic logic [47:0] pack4(input int a, input int b, input int c, input int d);
        logic [47:0] v;
        v[11:0]  = a[11:0];
        v[23:12] = b[11:0];
        v[35:24] = c[11:0];
        v[47:36] = d[11:0];
        return v;
    endfunction

    function automatic logic [PWORD_W-1:0] gen_word(input int a);
        logic [PWORD_W-1:0] w;
        for (int f = 0; f < MAX_IN + 1; f++) begin
            logic [31:0] h;
            h = a * 1103515245 + f * 12345 + 99 + a * f * 7;
            w[f*COEF_W +: COEF_W] = h[27:16];
        end
        return w;
    endfunction

    // Reference walk over the bench's own memory copies
    function automatic logic [OUT_W-1:0] model(input logic [47:0] x, input int n, input int d);
        int nc = clamp_n(n);
        int dc = clamp_d(d);
        int node = 0;
        for (int lvl = 0; lvl <= dc; lvl++) begin
            logic [PWORD_W-1:0] w;
            int s;
            w = par_m[tree_m[node]];
            s = int'($signed(w[11:0]));
            for (int j = 0; j < nc; j++) begin
                s += int'($signed(w[(j+1)*COEF_W +: COEF_W])) * int'($signed(x[j*IN_W +: IN_W]));
            end
            if (lvl == dc) return s[OUT_W-1:0];
            node = 2 * node + ((s > 0) ? 2 : 1);
        end
        return '0;
    endfunction

    // Monitor: pops expected items when the design reports a result
    always @(negedge clk) begin
        if (rst_n && valid_out) begin
            if (q_res.size() == 0) begin
                check(0, "R8", "unexpected result pulse", 1, 0);
            end else begin
                logic [OUT_W-1:0] er;
                int ec;
                string tg;
                er = q_res.pop_front();
                ec = q_cyc.pop_front();
                tg = q_tag.pop_front();
                last_exp = er;
                check(result === er, tg, "result", longint'($signed(result)), longint'($signed(er)));
                check(cyc == ec, "R5", "done cycle", cyc, ec);
            end
        end
    end

    // Driver: pushes the expected item and starts one evaluation
    task automatic run_eval(input logic [47:0] x, input int n, input int d,
                            input string tag, input bit disturb);
        @(negedge clk);
        x_in = x;
        n_inputs = n[2:0];
        depth = d[3:0];
        start = 1'b1;
        q_res.push_back(model(x, n, d));
        q_cyc.push_back(cyc + 1 + 2 * clamp_d(d) + 2);
        q_tag.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R5", "busy after start", busy, 1);
        if (disturb) begin
            // R10: change captured values; R8: extra start while busy
            x_in = ~x;
            n_inputs = 3'd1;
            depth = 4'd9;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (q_res.size() != 0) @(negedge clk);
        @(negedge clk);
        if (disturb) check(busy === 1'b0, "R8", "busy after ignored start", busy, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1 << TREE_AW); i++) tree_m[i] = PAR_AW'((i * 37 + 5) % (1 << PAR_AW));
        for (int a = 0; a < (1 << PAR_AW); a++) par_m[a] = gen_word(a);
        par_m[tree_m[0]][11:0] = '0;  // root offset zero: all-zero inputs give a zero sum

        repeat (3) @(negedge clk);
        check(busy === 1'b0, "R1", "busy in reset", busy, 0);
        check(valid_out === 1'b0, "R1", "valid in reset", valid_out, 0);
        check(result === '0, "R1", "result in reset", result, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && valid_out === 1'b0, "R1", "idle after reset", busy, 0);

        for (int i = 0; i < (1 << TREE_AW); i++) begin
            @(negedge clk);
            tree_we = 1'b1; tree_waddr = TREE_AW'(i); tree_wdata = tree_m[i];
        end
        for (int a = 0; a < (1 << PAR_AW); a++) begin
            @(negedge clk);
            tree_we = 1'b0;
            par_we = 1'b1; par_waddr = PAR_AW'(a); par_wdata = par_m[a];
        end
        @(negedge clk);
        par_we = 1'b0;

        run_eval(pack4(100, -200, 300, -400), 4, 1, "R2", 0);
        run_eval(pack4(2047, -2048, 2047, -2048), 4, 9, "R2", 0);
        run_eval(pack4(0, 0, 0, 0), 4, 1, "R4", 0);
        run_eval(pack4(0, 0, 0, 0), 4, 3, "R4", 0);
        for (int t = 0; t < 8; t++) begin
            run_eval(pack4(t * 311 - 1200, 900 - t * 257, t * 97, -t * 181), 4, t + 2, "R3", 0);
        end
        run_eval(pack4(500, 17, -33, 900), 2, 5, "R3", 0);
        run_eval(pack4(-700, 1500, -20, 6), 3, 9, "R5", 0);
        run_eval(pack4(321, -654, 987, -111), 4, 0, "R6", 0);
        run_eval(pack4(321, -654, 987, -111), 4, 15, "R6", 0);
        run_eval(pack4(-45, 2047, 2047, 2047), 1, 4, "R7", 0);
        run_eval(pack4(-45, 2047, 2047, 2047), 0, 4, "R7", 0);
        run_eval(pack4(812, -300, 2000, -2048), 7, 6, "R7", 0);
        run_eval(pack4(1234, -987, 456, -321), 4, 3, "R10", 1);
        run_eval(pack4(-1, 1, -1, 1), 4, 1, "R8", 1);

        repeat (6) @(negedge clk);
        check(result === last_exp, "R9", "result held while idle",
              longint'($signed(result)), longint'($signed(last_exp)));
        check(valid_out === 1'b0, "R9", "no pulse while idle", valid_out, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule